// File: doc/BRIEF.md
# Shared Memory Bank Cost Counter

This block works out how many serialized cycles one warp's shared-memory access needs when the memory is split into word-interleaved banks. Each lane supplies a byte address, and a mask says which lanes take part. The lanes are cut into `GROUPS` equal, contiguous sub-groups. Each sub-group is scored on its own, one sub-group per clock.

A sub-group's score is the largest number of requests that land on any single bank. Requests to the same word are not merged in general. Only one word per sub-group is treated as a broadcast. That word is the first word that has two or more requesters, searching from the lowest bank upward and then from the lowest word upward. All of its requesters count as a single access. The warp's cost is the sum of the sub-group scores.

A request enters through a valid/ready handshake. The block holds `in_ready` low while it is scoring. Anything presented during that time is ignored, and the source must hold its request until `in_ready` is high. The result leaves as a one-cycle `out_valid` pulse with no back-pressure. The cost and error outputs stay put until the next result.

Top module: `smem_bank_cost`

## Requirements
- R1: `in_ready` is high exactly when the block is idle. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. While busy, `in_valid`, `in_addr` and `in_mask` have no effect on the result in progress, and they do not start another result.
- R2: `out_valid` is high for exactly one cycle. It rises on the `GROUPS`-th clock edge after the edge that took the request.
- R3: A lane's word index is its address shifted right by log2(`WORD_BYTES`), so byte offsets inside a word do not matter. Its bank is the word index modulo `BANKS`. The defaults are 4-byte words and 32 banks.
- R4: A lane whose `in_mask` bit is 0 adds no access to any bank. Bit i of `in_mask` belongs to lane i, and lane i's address is `in_addr[i*ADDR_W +: ADDR_W]`.
- R5: Without a broadcast, a sub-group costs the largest count of active requests landing on one bank, with distinct words counted separately.
- R6: In each sub-group, exactly one word with two or more requesters is collapsed to a single access. It is the one with the lowest bank, and then the lowest word index within that bank. Any other repeated word still counts once per requester.
- R7: Sub-group g holds lanes g*`LANES`/`GROUPS` up to (g+1)*`LANES`/`GROUPS`-1. The cost on `out_cost` is the sum of all sub-group costs.
- R8: When at least one lane is active, `out_cost` lies between 1 and `LANES` inclusive.
- R9: A request with an all-zero mask yields `out_cost` = 0 and `out_err` = 1. Any other request yields `out_err` = 0.
- R10: During and right after reset, `in_ready` = 1, `out_valid` = 0, `out_cost` = 0 and `out_err` = 0.
- R11: `out_cost` and `out_err` only change on the edge that raises `out_valid`, and they hold their values until the next result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request can be taken |
| in_addr | input | LANES*ADDR_W (512) | Per-lane byte addresses, lane 0 in the low bits |
| in_mask | input | LANES (32) | Per-lane active bits |
| out_valid | output | 1 | One-cycle result pulse |
| out_cost | output | $clog2(LANES+1) (6) | Serialized bank cycles for the warp |
| out_err | output | 1 | Request had no active lane |

## Verification
The access patterns are strides of 1, 2, 4, 64 and 128 bytes, a single shared address, and repeating three-word cycles. The unit-stride and two-byte strides show that only one repeated word is merged and the others still conflict. The 128-byte stride puts every lane on bank 0 and reaches the upper bound. The three-word cycles are built so that choosing the broadcast by lane order or by requester count would give a different total from choosing it by lowest bank and then lowest word. Partial masks separate the two sub-groups and show that inactive lanes add nothing. A busy-time change of inputs, an empty mask and an offset within the word test the handshake, the error path and the word mapping.

// File: rtl/smem_bank_cost_pkg.sv
package smem_bank_cost_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/bcc_lane_map.sv
// Per-lane address to word index: drops the byte offset inside a word.
module bcc_lane_map #(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 16,
  parameter int WORD_SHIFT = 2,
  localparam int WW        = ADDR_W - WORD_SHIFT
) (
  input  logic [LANES*ADDR_W-1:0] addr_flat,
  output logic [LANES*WW-1:0]     word_flat
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign word_flat[l*WW +: WW] = addr_flat[l*ADDR_W + WORD_SHIFT +: WW];
  end
endmodule

// File: rtl/bcc_group_cost.sv
// Combinational score of one sub-group: worst bank load after one broadcast merge.
module bcc_group_cost #(
  parameter int GL     = 16,
  parameter int WW     = 14,
  parameter int BANK_W = 5,
  parameter int CNT_W  = 5
) (
  input  logic [GL*WW-1:0] words,
  input  logic [GL-1:0]    act,
  output logic [CNT_W-1:0] cost
);
  logic [WW-1:0]     w    [GL];
  logic [BANK_W-1:0] bk   [GL];
  logic [CNT_W-1:0]  cnt_w[GL];
  logic [CNT_W-1:0]  cnt_b[GL];
  logic              found;
  logic [BANK_W-1:0] bc_bank;
  logic [WW-1:0]     bc_word;
  logic [CNT_W-1:0]  bc_n;
  logic [CNT_W-1:0]  adj;

  for (genvar l = 0; l < GL; l++) begin : g_unpack
    assign w[l]  = words[l*WW +: WW];
    assign bk[l] = words[l*WW +: BANK_W];
  end

  // requesters of the same word and of the same bank, seen from each lane
  always_comb begin
    for (int i = 0; i < GL; i++) begin
      cnt_w[i] = '0;
      cnt_b[i] = '0;
      for (int j = 0; j < GL; j++) begin
        if (act[j] && (w[j] == w[i]))   cnt_w[i] = cnt_w[i] + CNT_W'(1);
        if (act[j] && (bk[j] == bk[i])) cnt_b[i] = cnt_b[i] + CNT_W'(1);
      end
    end
  end

  // broadcast pick: smallest {bank, word} among words with several requesters
  always_comb begin
    found   = 1'b0;
    bc_bank = '0;
    bc_word = '0;
    bc_n    = '0;
    for (int i = 0; i < GL; i++) begin
      if (act[i] && (cnt_w[i] > CNT_W'(1)) &&
          (!found || ({bk[i], w[i]} < {bc_bank, bc_word}))) begin
        found   = 1'b1;
        bc_bank = bk[i];
        bc_word = w[i];
        bc_n    = cnt_w[i];
      end
    end
  end

  always_comb begin
    cost = '0;
    adj  = '0;
    for (int i = 0; i < GL; i++) begin
      if (act[i]) begin
        adj = cnt_b[i];
        if (found && (bk[i] == bc_bank)) adj = cnt_b[i] - (bc_n - CNT_W'(1));
        if (adj > cost) cost = adj;
      end
    end
  end
endmodule

// File: rtl/bcc_seq.sv
// Captures a request, walks the sub-groups one per cycle and sums their scores.
module bcc_seq
  import smem_bank_cost_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int GROUPS = 2,
  parameter int WW     = 14,
  parameter int CNT_W  = 5,
  parameter int TOT_W  = 6,
  localparam int GL     = LANES / GROUPS,
  localparam int GIDX_W = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES*WW-1:0] word_flat,
  input  logic [LANES-1:0]    mask,
  output logic [GL*WW-1:0]    grp_words,
  output logic [GL-1:0]       grp_act,
  input  logic [CNT_W-1:0]    grp_cost,
  output logic                out_valid,
  output logic [TOT_W-1:0]    out_cost,
  output logic                out_err
);
  seq_state_e          state;
  logic [GIDX_W-1:0]   gidx;
  logic [LANES*WW-1:0] word_r;
  logic [LANES-1:0]    mask_r;
  logic [TOT_W-1:0]    acc;
  logic                err_r;
  logic [TOT_W-1:0]    sum;

  assign in_ready  = (state == ST_IDLE);
  assign grp_words = word_r[int'(gidx)*GL*WW +: GL*WW];
  assign grp_act   = mask_r[int'(gidx)*GL +: GL];
  assign sum       = acc + TOT_W'(grp_cost);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      gidx      <= '0;
      word_r    <= '0;
      mask_r    <= '0;
      acc       <= '0;
      err_r     <= 1'b0;
      out_valid <= 1'b0;
      out_cost  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            word_r <= word_flat;
            mask_r <= mask;
            err_r  <= (mask == '0);
            acc    <= '0;
            gidx   <= '0;
            state  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (gidx == GIDX_W'(GROUPS - 1)) begin
            out_cost  <= sum;
            out_err   <= err_r;
            out_valid <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            acc  <= sum;
            gidx <= gidx + GIDX_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smem_bank_cost.sv
module smem_bank_cost #(
  parameter int LANES      = 32,
  parameter int GROUPS     = 2,
  parameter int BANKS      = 32,
  parameter int ADDR_W     = 16,
  parameter int WORD_BYTES = 4,
  localparam int WORD_SHIFT = $clog2(WORD_BYTES),
  localparam int WW         = ADDR_W - WORD_SHIFT,
  localparam int GL         = LANES / GROUPS,
  localparam int BANK_W     = $clog2(BANKS),
  localparam int CNT_W      = $clog2(GL + 1),
  localparam int TOT_W      = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]        in_mask,
  output logic                    out_valid,
  output logic [TOT_W-1:0]        out_cost,
  output logic                    out_err
);
  logic [LANES*WW-1:0] word_flat;
  logic [GL*WW-1:0]    grp_words;
  logic [GL-1:0]       grp_act;
  logic [CNT_W-1:0]    grp_cost;

  bcc_lane_map #(
    .LANES(LANES), .ADDR_W(ADDR_W), .WORD_SHIFT(WORD_SHIFT)
  ) u_map (
    .addr_flat(in_addr),
    .word_flat(word_flat)
  );

  bcc_seq #(
    .LANES(LANES), .GROUPS(GROUPS), .WW(WW), .CNT_W(CNT_W), .TOT_W(TOT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .word_flat(word_flat), .mask(in_mask),
    .grp_words(grp_words), .grp_act(grp_act), .grp_cost(grp_cost),
    .out_valid(out_valid), .out_cost(out_cost), .out_err(out_err)
  );

  bcc_group_cost #(
    .GL(GL), .WW(WW), .BANK_W(BANK_W), .CNT_W(CNT_W)
  ) u_cost (
    .words(grp_words),
    .act(grp_act),
    .cost(grp_cost)
  );
endmodule

// File: rtl/smem_bank_cost_chk.sv
module smem_bank_cost_chk #(
  parameter int LANES  = 32,
  parameter int GROUPS = 2,
  parameter int TOT_W  = 6,
  localparam int CW    = $clog2(GROUPS + 2) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [TOT_W-1:0] out_cost,
  input logic             out_err
);
  logic [CW-1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    since <= '0;
    else if (in_valid && in_ready) since <= CW'(1);
    else if (out_valid)            since <= '0;
    else if (since != '0)          since <= since + CW'(1);
  end

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R1
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (since == CW'(GROUPS + 1))); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R2
  AST_COST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err) |-> ((out_cost >= TOT_W'(1)) && (out_cost <= TOT_W'(LANES)))); // R8
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_cost == '0)); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_cost) && $stable(out_err))); // R11
endmodule

bind smem_bank_cost smem_bank_cost_chk #(
  .LANES(LANES), .GROUPS(GROUPS), .TOT_W(TOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_cost(out_cost), .out_err(out_err)
);

// File: tb/test_smem_bank_cost.sv
`timescale 1ns/1ps
module test_smem_bank_cost;
  localparam int LANES = 32;
  localparam int G     = 2;
  localparam int AW    = 16;
  localparam int NV    = 13;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic            in_ready;
  logic [LANES*AW-1:0] in_addr;
  logic [LANES-1:0]    in_mask;
  logic            out_valid;
  logic [5:0]      out_cost;
  logic            out_err;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  smem_bank_cost i_smem_bank_cost (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_mask(in_mask),
    .out_valid(out_valid), .out_cost(out_cost), .out_err(out_err)
  );

  // {req, base, stride, mod (0 = none), mask, expected cost}
  // lane i address = base + stride * (mod ? i % mod : i)
  localparam logic [87:0] VEC [NV] = '{
    {8'd5, 16'd0,  16'd4,   8'd0, 32'hFFFF_FFFF, 8'd2},   // R5 unit word stride, no conflict
    {8'd3, 16'd3,  16'd4,   8'd0, 32'hFFFF_FFFF, 8'd2},   // R3 offset inside word ignored
    {8'd8, 16'd0,  16'd128, 8'd0, 32'hFFFF_FFFF, 8'd32},  // R8 all on bank 0, upper bound
    {8'd6, 16'd0,  16'd0,   8'd0, 32'hFFFF_FFFF, 8'd2},   // R6 one shared word
    {8'd5, 16'd0,  16'd64,  8'd0, 32'hFFFF_FFFF, 8'd16},  // R5 two banks, 8 each
    {8'd6, 16'd0,  16'd1,   8'd0, 32'hFFFF_FFFF, 8'd8},   // R6 four repeated words, one merged
    {8'd6, 16'd0,  16'd2,   8'd0, 32'hFFFF_FFFF, 8'd4},   // R6 pairs, one merged
    {8'd8, 16'd0,  16'd128, 8'd0, 32'h0000_0001, 8'd1},   // R8 lower bound
    {8'd4, 16'd0,  16'd128, 8'd0, 32'h0000_00FF, 8'd8},   // R4 masked lanes add nothing
    {8'd7, 16'd0,  16'd128, 8'd0, 32'hFFFF_0000, 8'd16},  // R7 upper sub-group alone
    {8'd6, 16'd0,  16'd128, 8'd3, 32'hFFFF_FFFF, 8'd23},  // R6 lowest word chosen in a bank
    {8'd6, 16'd20, 16'd116, 8'd3, 32'hFFFF_FFFF, 8'd11},  // R6 lowest bank chosen
    {8'd7, 16'd0,  16'd0,   8'd0, 32'h0001_0001, 8'd2}    // R7 one lane per sub-group
  };

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] base, input logic [15:0] stride,
                      input logic [7:0] md, input logic [31:0] mask);
    for (int i = 0; i < LANES; i++) begin
      logic [15:0] a;
      int k;
      k = (md == 0) ? i : (i % int'(md));
      a = base + 16'(int'(stride) * k);
      in_addr[i*AW +: AW] = a;
    end
    in_mask = mask;
  endtask

  task automatic run(input logic [15:0] base, input logic [15:0] stride,
                     input logic [7:0] md, input logic [31:0] mask, output int lat);
    @(negedge clk);
    load(base, stride, md, mask);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    summary();
  end

  initial begin
    int lat;
    logic [87:0] v;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_addr = '0;
    in_mask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 ready in reset", int'(in_ready), 1);
    chk("R10 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready after reset", int'(in_ready), 1);
    chk("R10 valid after reset", int'(out_valid), 0);
    chk("R10 cost after reset", int'(out_cost), 0);
    chk("R10 err after reset", int'(out_err), 0);

    // R1 nothing starts without in_valid
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk("R1 idle no result", int'(out_valid), 0);
    end

    for (int n = 0; n < NV; n++) begin
      v = VEC[n];
      run(v[79:64], v[63:48], v[47:40], v[39:8], lat);
      chk($sformatf("R%0d vec%0d cost", v[87:80], n), int'(out_cost), int'(v[7:0]));
      chk($sformatf("R9 vec%0d err", n), int'(out_err), 0);
      chk($sformatf("R2 vec%0d latency", n), lat, G);
      @(negedge clk);
      chk($sformatf("R2 vec%0d pulse ends", n), int'(out_valid), 0);
      chk($sformatf("R11 vec%0d cost held", n), int'(out_cost), int'(v[7:0]));
    end

    // R9 empty mask
    run(16'd0, 16'd4, 8'd0, 32'h0, lat);
    chk("R9 empty cost", int'(out_cost), 0);
    chk("R9 empty err", int'(out_err), 1);
    run(16'd0, 16'd4, 8'd0, 32'hFFFF_FFFF, lat);
    chk("R9 err clears", int'(out_err), 0);
    chk("R9 cost after clear", int'(out_cost), 2);

    // R1 inputs changed while busy are ignored
    @(negedge clk);
    load(16'd0, 16'd128, 8'd0, 32'hFFFF_FFFF);
    in_valid = 1'b1;
    @(negedge clk);
    chk("R1 busy not ready", int'(in_ready), 0);
    load(16'd0, 16'd0, 8'd0, 32'h0000_0001);
    lat = 0;
    while (!out_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    in_valid = 1'b0;
    chk("R1 busy change ignored", int'(out_cost), 32);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk("R1 no second result", int'(out_valid), 0);
    end
    chk("R11 hold after idle", int'(out_cost), 32);
    chk("R11 err hold", int'(out_err), 0);

    summary();
  end
endmodule